// File: doc/BRIEF.md
# Dual Comparator Port Front End

This block is the digital logic around a port that hosts two voltage comparators. Each comparator checks one of the port pins against a third pin that serves as a shared reference. The block receives the two comparator result bits, the digital pin levels, the stored latch bits of two output pins, a small mode register write, an edge-select field and the current power mode. From these it produces the value a port read returns, the drive levels of two output pins, a wake request for stop-mode recovery and single-cycle interrupt request pulses.

A two-bit mode register lives inside the block. Bit 1 turns on analog mode and bit 0 turns on the comparator-output overlay. In digital mode the two interrupt channels follow pins 1 and 2. In analog mode they follow the comparator results and the reference pin is kept away from interrupt sensing. Every interrupt and wake source goes through a two-flop synchronizer before edge or level detection. A stop-recovery reset clears the overlay bit and keeps the analog bit.

Top module: `cmp_port_logic`

## Requirements
- R1: While `rst_n` is low, `irq_o`, `irq_ref_o` and `wake_o` are 0, the mode register reads as digital with no overlay, and `pin4_drv`/`pin7_drv` equal `latch_p4`/`latch_p7`.
- R2: In analog mode (mode bit 1 = 1), outside stop, `port_rd` bit 1 is the synchronized channel 1 result (`cmp_raw[0]`), bit 2 is the synchronized channel 2 result (`cmp_raw[1]`), and the other bits are `pin_in`. A result change shows on the read after two clock edges.
- R3: In digital mode (mode bit 1 = 0), `port_rd` equals `pin_in`.
- R4: When analog mode and overlay (mode bit 0 = 1) are both set, `pin4_drv` carries channel 1 and `pin7_drv` carries channel 2. Otherwise the pins carry `latch_p4` and `latch_p7`, and they return to those values as soon as the overlay is cleared.
- R5: With `edge_sel` = 00, both channels request an interrupt on a falling edge of their source.
- R6: With `edge_sel` = 01, channel 1 fires on a falling edge and channel 2 fires on a rising edge.
- R7: With `edge_sel` = 10, both channels fire on a rising edge.
- R8: With `edge_sel` = 11, both channels fire on either edge.
- R9: `irq_ref_o` pulses on a falling edge of pin 3 in digital mode only. It is always 0 in analog mode.
- R10: Halt (`pwr_mode` = 01) behaves the same as run (00) for reads, overlays and interrupts.
- R11: In stop (`pwr_mode` = 10), `irq_o` and `irq_ref_o` stay 0. In analog mode, read bits 1 and 2 are 0 and overlaid pins drive 0.
- R12: `wake_o` is 1 only in stop with digital mode, after any of pins 1 to 3 has been sampled low by the synchronizer. In analog mode it stays 0.
- R13: A one-cycle `recov_rst` clears the overlay bit and keeps the analog bit. `recov_rst` takes priority over a write in the same cycle.
- R14: Each qualifying edge produces exactly one interrupt pulse, one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low full reset |
| recov_rst | input | 1 | Synchronous stop-recovery reset pulse |
| pwr_mode | input | 2 | 00 run, 01 halt, 10 stop, 11 treated as run |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Bit 1 analog enable, bit 0 overlay enable |
| edge_sel | input | 2 | Interrupt edge selection |
| cmp_raw | input | 2 | Comparator results, bit 0 channel 1, bit 1 channel 2 |
| pin_in | input | 8 | Digital pin levels |
| latch_p4 | input | 1 | Stored output latch bit of pin 4 |
| latch_p7 | input | 1 | Stored output latch bit of pin 7 |
| port_rd | output | 8 | Port read value |
| pin4_drv | output | 1 | Drive level of pin 4 |
| pin7_drv | output | 1 | Drive level of pin 7 |
| irq_o | output | 2 | Interrupt pulses, bit 0 channel 1, bit 1 channel 2 |
| irq_ref_o | output | 1 | Interrupt pulse from pin 3 (digital mode only) |
| wake_o | output | 1 | Stop-recovery wake request |

## Verification
The hardest state to reach from the ports is a stop-recovery reset that arrives while both analog mode and the overlay are set. The internal mode register can only be seen through the read overlay and the pin drive. The stimulus therefore writes both mode bits, confirms the overlay on the pins, pulses `recov_rst`, and then checks two things: the pins fall back to their latch bits while the comparator results still appear in the read. The edge-select matrix is driven from a table. Each entry parks the comparator inputs on one level for several cycles, then counts pulse-high cycles in a window after a single change, which checks both the edge choice and the one-cycle pulse width.

// File: rtl/cmp_port_pkg.sv
package cmp_port_pkg;
  typedef enum logic [1:0] {
    PWR_RUN  = 2'b00,
    PWR_HALT = 2'b01,
    PWR_STOP = 2'b10,
    PWR_RSVD = 2'b11
  } pwr_e;

  localparam int MODE_W     = 2;
  localparam int OVL_BIT    = 0;
  localparam int ANALOG_BIT = 1;

  typedef struct packed {
    logic rise1;
    logic fall1;
    logic rise2;
    logic fall2;
  } edge_cfg_t;

  function automatic edge_cfg_t decode_edge(input logic [1:0] sel);
    edge_cfg_t c;
    case (sel)
      2'b00:   c = '{rise1: 1'b0, fall1: 1'b1, rise2: 1'b0, fall2: 1'b1};
      2'b01:   c = '{rise1: 1'b0, fall1: 1'b1, rise2: 1'b1, fall2: 1'b0};
      2'b10:   c = '{rise1: 1'b1, fall1: 1'b0, rise2: 1'b1, fall2: 1'b0};
      default: c = '{rise1: 1'b1, fall1: 1'b1, rise2: 1'b1, fall2: 1'b1};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stg_d[g] = d;
    end else begin : g_next
      assign stg_d[g] = stg_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cmp_edge.sv
module cmp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise_en,
  input  logic fall_en,
  output logic pulse
);
  logic prev_q, pulse_q, hit_d;

  always_comb begin
    hit_d = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= lvl;
      pulse_q <= hit_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/cmp_mode_reg.sv
module cmp_mode_reg
  import cmp_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MODE_W-1:0] wdata,
  input  logic              recov,
  output logic [MODE_W-1:0] mode
);
  localparam logic [MODE_W-1:0] KEEP_MASK = MODE_W'(1) << ANALOG_BIT;

  logic [MODE_W-1:0] mode_q, mode_d;
  logic              mode_en;

  always_comb begin
    mode_en = we | recov;
    mode_d  = wdata;
    if (recov) mode_d = mode_q & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/cmp_port_logic.sv
module cmp_port_logic
  import cmp_port_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recov_rst,
  input  logic [1:0]        pwr_mode,
  input  logic              mode_we,
  input  logic [1:0]        mode_wdata,
  input  logic [1:0]        edge_sel,
  input  logic [1:0]        cmp_raw,
  input  logic [PORT_W-1:0] pin_in,
  input  logic              latch_p4,
  input  logic              latch_p7,
  output logic [PORT_W-1:0] port_rd,
  output logic              pin4_drv,
  output logic              pin7_drv,
  output logic [1:0]        irq_o,
  output logic              irq_ref_o,
  output logic              wake_o
);
  localparam int NSRC = 3;

  logic [MODE_W-1:0] mode_q;
  logic              analog, ovl, stop;
  logic [NSRC-1:0]   src, lvl, pulse, rise_en, fall_en;
  logic [1:0]        cmp_vis;
  edge_cfg_t         cfg;
  logic              wake_q, wake_d;

  cmp_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mode_we),
    .wdata (mode_wdata),
    .recov (recov_rst),
    .mode  (mode_q)
  );

  always_comb begin
    analog = mode_q[ANALOG_BIT];
    ovl    = analog & mode_q[OVL_BIT];
    stop   = (pwr_e'(pwr_mode) == PWR_STOP);
    src[0] = analog ? cmp_raw[0] : pin_in[1];
    src[1] = analog ? cmp_raw[1] : pin_in[2];
    src[2] = pin_in[3];
  end

  cmp_sync #(.W(NSRC), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (src),
    .q     (lvl)
  );

  always_comb begin
    cfg     = decode_edge(edge_sel);
    rise_en = {1'b0, cfg.rise2, cfg.rise1};
    fall_en = {1'b1, cfg.fall2, cfg.fall1};
  end

  for (genvar c = 0; c < NSRC; c++) begin : g_edge
    cmp_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (lvl[c]),
      .rise_en (rise_en[c]),
      .fall_en (fall_en[c]),
      .pulse   (pulse[c])
    );
  end

  always_comb begin
    cmp_vis = stop ? 2'b00 : lvl[1:0];
    port_rd = pin_in;
    if (analog) begin
      port_rd[1] = cmp_vis[0];
      port_rd[2] = cmp_vis[1];
    end
    pin4_drv  = ovl ? cmp_vis[0] : latch_p4;
    pin7_drv  = ovl ? cmp_vis[1] : latch_p7;
    irq_o     = pulse[1:0] & {2{~stop}};
    irq_ref_o = pulse[2] & ~analog & ~stop;
    wake_d    = stop & ~analog & ~(&lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  assign wake_o = wake_q & stop & ~analog;
endmodule

// File: rtl/cmp_port_chk.sv
module cmp_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       recov_rst,
  input logic       mode_we,
  input logic [1:0] mode_q,
  input logic [1:0] pwr_mode,
  input logic [7:0] pin_in,
  input logic [7:0] port_rd,
  input logic       latch_p4,
  input logic       latch_p7,
  input logic       pin4_drv,
  input logic       pin7_drv,
  input logic [1:0] irq_o,
  input logic       irq_ref_o,
  input logic       wake_o
);
  p_digital_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[1] |-> port_rd == pin_in);

  p_latch_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_q[1] && mode_q[0]) |-> (pin4_drv == latch_p4 && pin7_drv == latch_p7));

  p_ref_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] |-> !irq_ref_o);

  p_stop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode == 2'b10 |-> (irq_o == 2'b00 && !irq_ref_o));

  p_stop_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b10 && mode_q[1]) |-> port_rd[2:1] == 2'b00);

  p_wake_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (pwr_mode == 2'b10 && !mode_q[1]));

  p_keep_analog_r13: assert property (@(posedge clk) disable iff (!rst_n)
    recov_rst |=> (mode_q[1] == $past(mode_q[1]) && !mode_q[0]));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (irq_o == 2'b00 && !irq_ref_o && !wake_o));
endmodule

bind cmp_port_logic cmp_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .recov_rst (recov_rst),
  .mode_we   (mode_we),
  .mode_q    (mode_q),
  .pwr_mode  (pwr_mode),
  .pin_in    (pin_in),
  .port_rd   (port_rd),
  .latch_p4  (latch_p4),
  .latch_p7  (latch_p7),
  .pin4_drv  (pin4_drv),
  .pin7_drv  (pin7_drv),
  .irq_o     (irq_o),
  .irq_ref_o (irq_ref_o),
  .wake_o    (wake_o)
);

// File: tb/cmp_port_logic_bench.sv
module cmp_port_logic_bench;
  logic       clk = 1'b0;
  logic       rst_n, recov_rst, mode_we, latch_p4, latch_p7;
  logic [1:0] pwr_mode, mode_wdata, edge_sel, cmp_raw;
  logic [7:0] pin_in, port_rd;
  logic       pin4_drv, pin7_drv, irq_ref_o, wake_o;
  logic [1:0] irq_o;

  int n_chk = 0, n_fail = 0;
  int cnt1 = 0, cnt2 = 0, cnt3 = 0;
  bit cnt_en = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_port_logic u_cmp_port_logic (
    .clk(clk), .rst_n(rst_n), .recov_rst(recov_rst), .pwr_mode(pwr_mode),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .edge_sel(edge_sel),
    .cmp_raw(cmp_raw), .pin_in(pin_in), .latch_p4(latch_p4), .latch_p7(latch_p7),
    .port_rd(port_rd), .pin4_drv(pin4_drv), .pin7_drv(pin7_drv),
    .irq_o(irq_o), .irq_ref_o(irq_ref_o), .wake_o(wake_o)
  );

  always @(negedge clk) begin
    if (cnt_en) begin
      cnt1 += int'(irq_o[0]);
      cnt2 += int'(irq_o[1]);
      cnt3 += int'(irq_ref_o);
    end
  end

  // entry: sel[7:6], start[5:4], end[3:2], expected pulses {ch2,ch1}[1:0]
  localparam logic [7:0] VEC [0:8] = '{
    8'b00_00_11_00, // R5 rise ignored
    8'b00_11_00_11, // R5 both fall
    8'b00_01_10_01, // R5 ch1 falls, ch2 rises
    8'b01_00_11_10, // R6 ch2 rising
    8'b01_11_00_01, // R6 ch1 falling
    8'b10_00_11_11, // R7 both rise
    8'b10_11_00_00, // R7 fall ignored
    8'b11_00_11_11, // R8 any edge
    8'b11_11_00_11  // R8 any edge
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [1:0] m);
    mode_we = 1'b1; mode_wdata = m;
    step(1);
    mode_we = 1'b0;
    step(4);
  endtask

  task automatic window(input logic [1:0] sel, input logic [1:0] st, input logic [1:0] en,
                        output int c1, output int c2);
    edge_sel = sel; cmp_raw = st;
    step(6);
    cnt1 = 0; cnt2 = 0; cnt3 = 0; cnt_en = 1'b1;
    cmp_raw = en;
    step(8);
    cnt_en = 1'b0;
    c1 = cnt1; c2 = cnt2;
  endtask

  initial begin
    int c1, c2;
    rst_n = 1'b0; recov_rst = 1'b0; pwr_mode = 2'b00; mode_we = 1'b0;
    mode_wdata = 2'b00; edge_sel = 2'b00; cmp_raw = 2'b00; pin_in = 8'hFF;
    latch_p4 = 1'b1; latch_p7 = 1'b0;
    step(3);
    chk("R1 irq", {30'd0, irq_o}, 0);
    chk("R1 wake", {31'd0, wake_o}, 0);
    chk("R1 pins", {30'd0, pin7_drv, pin4_drv}, 32'h1);
    rst_n = 1'b1;
    step(6);
    // R3: digital reads follow pins
    pin_in = 8'h5A; step(1);
    chk("R3 digital read", {24'd0, port_rd}, 32'h5A);
    // R2: analog read overlay
    write_mode(2'b10);
    pin_in = 8'hA5; cmp_raw = 2'b01; step(3);
    chk("R2 analog read", {24'd0, port_rd}, {24'd0, pin_in[7:3], cmp_raw[1], cmp_raw[0], pin_in[0]});
    cmp_raw = 2'b10; step(3);
    chk("R2 analog read 2", {24'd0, port_rd}, {24'd0, pin_in[7:3], 2'b10, pin_in[0]});
    // R4: overlay on pins
    write_mode(2'b11);
    latch_p4 = 1'b0; latch_p7 = 1'b0; cmp_raw = 2'b11; step(3);
    chk("R4 overlay on", {30'd0, pin7_drv, pin4_drv}, 32'h3);
    latch_p4 = 1'b1; latch_p7 = 1'b1; cmp_raw = 2'b00; step(3);
    chk("R4 overlay hides latch", {30'd0, pin7_drv, pin4_drv}, 32'h0);
    write_mode(2'b10);
    chk("R4 latch restored", {30'd0, pin7_drv, pin4_drv}, 32'h3);
    // R5..R8, R14: edge-select table
    for (int i = 0; i < 9; i++) begin
      window(VEC[i][7:6], VEC[i][5:4], VEC[i][3:2], c1, c2);
      chk($sformatf("R14 edge vector %0d ch1", i), c1, {31'd0, VEC[i][0]});
      chk($sformatf("R14 edge vector %0d ch2", i), c2, {31'd0, VEC[i][1]});
    end
    // R10: halt acts like run
    pwr_mode = 2'b01;
    window(2'b00, 2'b11, 2'b00, c1, c2);
    chk("R10 halt ch1", c1, 1);
    chk("R10 halt ch2", c2, 1);
    // R11: stop suppresses
    write_mode(2'b11);
    latch_p4 = 1'b1;
    pwr_mode = 2'b10;
    window(2'b11, 2'b00, 2'b11, c1, c2);
    chk("R11 stop irq", c1 + c2, 0);
    chk("R11 stop read", {30'd0, port_rd[2:1]}, 0);
    chk("R11 stop pin4", {31'd0, pin4_drv}, 0);
    chk("R12 analog no wake", {31'd0, wake_o}, 0);
    pwr_mode = 2'b00; step(6);
    // R13: recovery keeps analog, clears overlay
    chk("R13 overlay before", {31'd0, pin4_drv}, 1);
    latch_p4 = 1'b0; step(1);
    recov_rst = 1'b1; step(1); recov_rst = 1'b0; step(2);
    chk("R13 overlay cleared", {31'd0, pin4_drv}, 0);
    chk("R13 analog kept", {30'd0, port_rd[2:1]}, 32'h3);
    // R9: reference pin interrupts
    write_mode(2'b00);
    pin_in = 8'hFF; step(6);
    cnt3 = 0; cnt_en = 1'b1; pin_in[3] = 1'b0; step(8); cnt_en = 1'b0;
    chk("R9 digital ref irq", cnt3, 1);
    pin_in[3] = 1'b1; step(6);
    write_mode(2'b10);
    cnt3 = 0; cnt_en = 1'b1; pin_in[3] = 1'b0; step(8); cnt_en = 1'b0;
    chk("R9 analog ref quiet", cnt3, 0);
    // R12: wake in digital stop
    pin_in = 8'hFF;
    write_mode(2'b00);
    pwr_mode = 2'b10; step(5);
    chk("R12 no wake high pins", {31'd0, wake_o}, 0);
    pin_in[2] = 1'b0; step(4);
    chk("R12 wake low pin", {31'd0, wake_o}, 1);
    pwr_mode = 2'b00; step(1);
    chk("R12 wake only stop", {31'd0, wake_o}, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule